// File: doc/BRIEF.md
# Decrement-and-Skip Execution Slice

This block executes the two conditional-skip instructions of a small 8-bit accumulator-style processor. One instruction lowers a data-file byte by one and skips the following instruction when the new value is zero. The other does the same decrement but skips when the new value is non-zero. The block holds the working register, the bank selector and a banked byte-wide data file. It runs every instruction cycle as four clock phases: decode, read, compute and write.

When the skip condition holds, the next instruction has already been fetched, so the block throws it away and runs empty instruction cycles in its place. It runs one empty cycle, or two when the fetch stage marked the discarded instruction as a two-word instruction. A `busy` output tells the fetch stage to hold. At the end of the instruction, `done` strobes together with the number of program words to advance and the number of instruction cycles used. A plain write and read port lets the neighbouring logic load and inspect the data file while the slice is idle.

Top module: `dsk_unit`

## Requirements
- R1: An instruction is accepted only while the slice is idle, `instr_valid` is high and bits [15:10] of the word are 001011 (skip when zero) or 010011 (skip when non-zero). Any other word leaves `busy` low and changes no state.
- R2: The computed value is the addressed byte minus one, modulo 256, so 0x00 gives 0xFF. All status is left untouched.
- R3: Word bit 9 picks the destination. When it is 0 the result goes to the working register and the file byte keeps its value. When it is 1 the result goes to the file byte and the working register keeps its value.
- R4: Word bit 8 picks the bank. When it is 0, file addresses 0x00–0x7F go to bank 0 and 0x80–0xFF go to the all-ones bank. When it is 1, the bank selector supplies the bank. The data address is {bank, bits[7:0]}.
- R5: The zero-variant skips exactly when the result is 0x00. The non-zero variant skips exactly when the result is not 0x00.
- R6: An instruction cycle is four clocks. An instruction uses 1 cycle without a skip, 2 with a skip, and 3 with a skip when `next_two_word` was high at acceptance. `done` is high only in the last clock, which is clock 4×cycles counted from the accepting clock.
- R7: While `done` is high, `pc_advance` and `cycles_used` both equal 1, 2 or 3 as in R6. At all other times both read 0.
- R8: `busy` is high from the clock after acceptance through the `done` clock. `nop_active` is high only during the empty skip cycles. `instr_valid` is ignored while `busy` is high.
- R9: `phase_out` steps through 0,1,2,3 (decode, read, compute, write) in every instruction cycle, and reads 0 when idle.
- R10: Synchronous reset clears the working register, the bank selector and the phase. It also aborts any instruction in flight, so `busy` is low afterwards.
- R11: A write on the external file port is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Fetch stage presents an instruction word |
| instr_word | input | 16 | Instruction word |
| next_two_word | input | 1 | Prefetched next instruction is two words long |
| bsr_load | input | 1 | Load the bank selector |
| bsr_value | input | 4 | New bank selector value |
| ext_wr_en | input | 1 | External data-file write strobe |
| ext_wr_addr | input | 12 | External write address |
| ext_wr_data | input | 8 | External write data |
| ext_rd_addr | input | 12 | External read address |
| ext_rd_data | output | 8 | External read data (combinational) |
| wreg_out | output | 8 | Working register |
| busy | output | 1 | Fetch stage must hold |
| nop_active | output | 1 | Empty skip cycle in progress |
| phase_out | output | 2 | Current phase, 0 to 3 |
| done | output | 1 | Last clock of the instruction |
| pc_advance | output | 2 | Program words to advance, valid with done |
| cycles_used | output | 2 | Instruction cycles used, valid with done |

## Verification
The assertions assume that `instr_valid` is only meaningful when the slice is idle. They also assume that `next_two_word` is valid in the accepting clock and that external writes carry no meaning while `busy` is high. The stimulus drives all inputs at the falling edge. It raises `instr_valid` for exactly the accepting clock, except in the directed case that deliberately holds it high during `busy` to exercise R8. It writes the file and the bank selector only between instructions, except in the R11 case, which writes on purpose while `busy` is high.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
    localparam int DATA_W  = 8;
    localparam int BANK_W  = 4;
    localparam int FADDR_W = 8;
    localparam int WORD_W  = 16;
    localparam int OPC_W   = 6;

    localparam logic [OPC_W-1:0] OPC_DEC_SKIP_Z  = 6'b001011;
    localparam logic [OPC_W-1:0] OPC_DEC_SKIP_NZ = 6'b010011;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_SKIP = 2'd2
    } state_t;

    typedef struct packed {
        logic               known;
        logic               skip_on_zero;
        logic               to_file;
        logic               use_bsr;
        logic [FADDR_W-1:0] faddr;
    } dec_t;

    function automatic dec_t decode_word(input logic [WORD_W-1:0] w);
        dec_t d;
        d.known        = (w[15:10] == OPC_DEC_SKIP_Z) || (w[15:10] == OPC_DEC_SKIP_NZ);
        d.skip_on_zero = (w[15:10] == OPC_DEC_SKIP_Z);
        d.to_file      = w[9];
        d.use_bsr      = w[8];
        d.faddr        = w[FADDR_W-1:0];
        return d;
    endfunction
endpackage

// File: rtl/dsk_addr_gen.sv
module dsk_addr_gen #(
    parameter int BANK_W  = 4,
    parameter int FADDR_W = 8,
    localparam int ADDR_W = BANK_W + FADDR_W
) (
    input  logic               use_bsr,
    input  logic [BANK_W-1:0]  bsr,
    input  logic [FADDR_W-1:0] faddr,
    output logic [ADDR_W-1:0]  addr
);
    logic [BANK_W-1:0] bank;

    always_comb begin
        if (use_bsr)
            bank = bsr;
        else if (faddr[FADDR_W-1])
            bank = '1;
        else
            bank = '0;
        addr = {bank, faddr};
    end
endmodule

// File: rtl/dsk_alu.sv
module dsk_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic              skip_on_zero,
    output logic [DATA_W-1:0] result,
    output logic              skip
);
    logic is_zero;

    always_comb begin
        result  = operand - DATA_W'(1);
        is_zero = (result == '0);
        skip    = skip_on_zero ? is_zero : !is_zero;
    end
endmodule

// File: rtl/dsk_file.sv
module dsk_file #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 12,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_core,
    input  logic [ADDR_W-1:0] waddr_core,
    input  logic [DATA_W-1:0] wdata_core,
    input  logic              we_ext,
    input  logic [ADDR_W-1:0] waddr_ext,
    input  logic [DATA_W-1:0] wdata_ext,
    input  logic [ADDR_W-1:0] raddr_core,
    output logic [DATA_W-1:0] rdata_core,
    input  logic [ADDR_W-1:0] raddr_ext,
    output logic [DATA_W-1:0] rdata_ext
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_core)
            mem[waddr_core] <= wdata_core;
        else if (we_ext)
            mem[waddr_ext] <= wdata_ext;
    end

    assign rdata_core = mem[raddr_core];
    assign rdata_ext  = mem[raddr_ext];

    // The gated external strobe never meets a core write-back
    assert_single_writer_R11: assert property (@(posedge clk) disable iff (rst)
        !(we_core && we_ext));
endmodule

// File: rtl/dsk_seq.sv
module dsk_seq
    import dsk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   skip_req,
    input  logic   two_word,
    output state_t state,
    output phase_t phase,
    output logic   done
);
    logic [1:0] nops_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= PH_Q1;
            nops_left <= 2'd0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_EXEC;
                        phase <= PH_Q2;
                    end
                end
                ST_EXEC: begin
                    if (phase == PH_Q4) begin
                        phase <= PH_Q1;
                        if (skip_req) begin
                            state     <= ST_SKIP;
                            nops_left <= two_word ? 2'd2 : 2'd1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        phase <= phase_t'(phase + 2'd1);
                    end
                end
                ST_SKIP: begin
                    if (phase == PH_Q4) begin
                        phase <= PH_Q1;
                        if (nops_left == 2'd1) begin
                            state     <= ST_IDLE;
                            nops_left <= 2'd0;
                        end else begin
                            nops_left <= nops_left - 2'd1;
                        end
                    end else begin
                        phase <= phase_t'(phase + 2'd1);
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    phase <= PH_Q1;
                end
            endcase
        end
    end

    assign done = (phase == PH_Q4) &&
                  (((state == ST_EXEC) && !skip_req) ||
                   ((state == ST_SKIP) && (nops_left == 2'd1)));

    assert_start_enters_exec_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> (state == ST_EXEC) && (phase == PH_Q2));
    assert_done_returns_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> (state == ST_IDLE) && (phase == PH_Q1));
    assert_skip_has_budget_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> (nops_left == 2'd1 || nops_left == 2'd2));
    assert_idle_phase_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (phase == PH_Q1));
endmodule

// File: rtl/dsk_unit.sv
module dsk_unit
    import dsk_pkg::*;
#(
    parameter int BANK_W  = dsk_pkg::BANK_W,
    parameter int FADDR_W = dsk_pkg::FADDR_W,
    parameter int DATA_W  = dsk_pkg::DATA_W,
    localparam int ADDR_W = BANK_W + FADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [15:0]       instr_word,
    input  logic              next_two_word,
    input  logic              bsr_load,
    input  logic [BANK_W-1:0] bsr_value,
    input  logic              ext_wr_en,
    input  logic [ADDR_W-1:0] ext_wr_addr,
    input  logic [DATA_W-1:0] ext_wr_data,
    input  logic [ADDR_W-1:0] ext_rd_addr,
    output logic [DATA_W-1:0] ext_rd_data,
    output logic [DATA_W-1:0] wreg_out,
    output logic              busy,
    output logic              nop_active,
    output logic [1:0]        phase_out,
    output logic              done,
    output logic [1:0]        pc_advance,
    output logic [1:0]        cycles_used
);
    dec_t              dec_now;
    logic              start;
    state_t            state;
    phase_t            phase;
    logic [ADDR_W-1:0] addr_now;
    logic [ADDR_W-1:0] addr_q;
    logic [BANK_W-1:0] bsr_q;
    logic              sz_q, to_file_q, two_q;
    logic [DATA_W-1:0] wreg_q, data_q, res_q, file_rdata, alu_res;
    logic              alu_skip, skip_q;
    logic [1:0]        adv_q;
    logic              exec_q2, exec_q3, exec_q4;

    assign dec_now = decode_word(instr_word);
    assign start   = instr_valid && dec_now.known && (state == ST_IDLE);
    assign exec_q2 = (state == ST_EXEC) && (phase == PH_Q2);
    assign exec_q3 = (state == ST_EXEC) && (phase == PH_Q3);
    assign exec_q4 = (state == ST_EXEC) && (phase == PH_Q4);

    dsk_addr_gen #(.BANK_W(BANK_W), .FADDR_W(FADDR_W)) u_addr (
        .use_bsr (dec_now.use_bsr),
        .bsr     (bsr_q),
        .faddr   (dec_now.faddr),
        .addr    (addr_now)
    );

    dsk_alu #(.DATA_W(DATA_W)) u_alu (
        .operand      (data_q),
        .skip_on_zero (sz_q),
        .result       (alu_res),
        .skip         (alu_skip)
    );

    dsk_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .skip_req (skip_q),
        .two_word (two_q),
        .state    (state),
        .phase    (phase),
        .done     (done)
    );

    dsk_file #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_file (
        .clk        (clk),
        .rst        (rst),
        .we_core    (exec_q4 && to_file_q),
        .waddr_core (addr_q),
        .wdata_core (res_q),
        .we_ext     (ext_wr_en && !busy),
        .waddr_ext  (ext_wr_addr),
        .wdata_ext  (ext_wr_data),
        .raddr_core (addr_q),
        .rdata_core (file_rdata),
        .raddr_ext  (ext_rd_addr),
        .rdata_ext  (ext_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wreg_q    <= '0;
            bsr_q     <= '0;
            addr_q    <= '0;
            sz_q      <= 1'b0;
            to_file_q <= 1'b0;
            two_q     <= 1'b0;
            data_q    <= '0;
            res_q     <= '0;
            skip_q    <= 1'b0;
            adv_q     <= 2'd0;
        end else begin
            if (bsr_load)
                bsr_q <= bsr_value;
            if (start) begin
                addr_q    <= addr_now;
                sz_q      <= dec_now.skip_on_zero;
                to_file_q <= dec_now.to_file;
                two_q     <= next_two_word;
                skip_q    <= 1'b0;
            end
            if (exec_q2)
                data_q <= file_rdata;
            if (exec_q3) begin
                res_q  <= alu_res;
                skip_q <= alu_skip;
                adv_q  <= alu_skip ? (two_q ? 2'd3 : 2'd2) : 2'd1;
            end
            if (exec_q4 && !to_file_q)
                wreg_q <= res_q;
        end
    end

    assign busy        = (state != ST_IDLE);
    assign nop_active  = (state == ST_SKIP);
    assign phase_out   = phase;
    assign wreg_out    = wreg_q;
    assign pc_advance  = done ? adv_q : 2'd0;
    assign cycles_used = done ? adv_q : 2'd0;

    assert_unknown_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy && instr_valid && !dec_now.known) |=> !busy);
    assert_wreg_writeback_R3: assert property (@(posedge clk) disable iff (rst)
        (exec_q4 && !to_file_q) |=> (wreg_out == $past(res_q)));
    assert_wreg_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (exec_q4 && to_file_q) |=> $stable(wreg_out));
    assert_access_bank_R4: assert property (@(posedge clk) disable iff (rst)
        (start && !instr_word[8]) |=>
            (addr_q[ADDR_W-1 -: BANK_W] == {BANK_W{$past(instr_word[FADDR_W-1])}}));
    assert_advance_range_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (pc_advance != 2'd0));
    assert_nop_starts_q1_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(nop_active) |-> (phase_out == 2'd0) && $past(busy));
endmodule

// File: tb/dsk_unit_test.sv
`timescale 1ns/1ps
module dsk_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        next_two_word = 1'b0;
    logic        bsr_load = 1'b0;
    logic [3:0]  bsr_value = '0;
    logic        ext_wr_en = 1'b0;
    logic [11:0] ext_wr_addr = '0;
    logic [7:0]  ext_wr_data = '0;
    logic [11:0] ext_rd_addr = '0;
    logic [7:0]  ext_rd_data, wreg_out;
    logic        busy, nop_active, done;
    logic [1:0]  phase_out, pc_advance, cycles_used;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] w_model = 8'h00;

    always #2.5 clk = ~clk;

    dsk_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .next_two_word(next_two_word), .bsr_load(bsr_load), .bsr_value(bsr_value),
        .ext_wr_en(ext_wr_en), .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data),
        .ext_rd_addr(ext_rd_addr), .ext_rd_data(ext_rd_data), .wreg_out(wreg_out),
        .busy(busy), .nop_active(nop_active), .phase_out(phase_out), .done(done),
        .pc_advance(pc_advance), .cycles_used(cycles_used)
    );

    typedef struct packed {
        logic [15:0] word;
        logic        two;
        logic [3:0]  bsr;
        logic [11:0] addr;
        logic [7:0]  init;
        logic [7:0]  res;
        logic [1:0]  cyc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{16'h2E10, 1'b0, 4'h0, 12'h010, 8'h05, 8'h04, 2'd1},
        '{16'h2C20, 1'b0, 4'h0, 12'h020, 8'h01, 8'h00, 2'd2},
        '{16'h2F44, 1'b1, 4'h3, 12'h344, 8'h01, 8'h00, 2'd3},
        '{16'h2E85, 1'b0, 4'h3, 12'hF85, 8'h00, 8'hFF, 2'd1},
        '{16'h4E30, 1'b1, 4'h3, 12'h030, 8'h01, 8'h00, 2'd1},
        '{16'h4D90, 1'b1, 4'h5, 12'h590, 8'h80, 8'h7F, 2'd3},
        '{16'h4CFF, 1'b0, 4'h5, 12'hFFF, 8'h00, 8'hFF, 2'd2},
        '{16'h2F01, 1'b0, 4'hF, 12'hF01, 8'h02, 8'h01, 2'd1}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic file_write(input logic [11:0] a, input logic [7:0] d);
        ext_wr_en = 1'b1; ext_wr_addr = a; ext_wr_data = d;
        tick();
        ext_wr_en = 1'b0;
    endtask

    task automatic file_read(input logic [11:0] a, output logic [7:0] d);
        ext_rd_addr = a;
        #0.1;
        d = ext_rd_data;
    endtask

    task automatic load_bsr(input logic [3:0] b);
        bsr_load = 1'b1; bsr_value = b;
        tick();
        bsr_load = 1'b0;
    endtask

    task automatic wait_done;
        for (int i = 0; i < 20 && !done; i++) tick();
    endtask

    // Issue one instruction and check its clock-by-clock sequence (R6 R8 R9) and counts (R7)
    task automatic run_instr(input logic [15:0] w, input logic two, input int cyc);
        int errs = 0;
        int k = 2;
        logic [1:0] adv = 2'd0;
        logic [1:0] cu  = 2'd0;
        instr_word = w; next_two_word = two; instr_valid = 1'b1;
        if (busy || phase_out != 2'd0) errs++;
        tick();
        instr_valid = 1'b0;
        while (k <= 16) begin
            if (!busy) errs++;
            if (phase_out != 2'((k - 1) % 4)) errs++;
            if (nop_active != (k > 4)) errs++;
            if (done != (k == 4 * cyc)) errs++;
            if (done) begin
                adv = pc_advance; cu = cycles_used;
                break;
            end
            tick();
            k++;
        end
        check(errs == 0 && k == 4 * cyc, "R6 R8 R9 clock sequence", k, 4 * cyc);
        check(adv == 2'(cyc) && cu == 2'(cyc), "R7 advance and cycles", {adv, cu}, {2'(cyc), 2'(cyc)});
        tick();
        check(!busy && pc_advance == 2'd0, "R7 R8 idle after done", {busy, pc_advance}, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(wreg_out == 8'h00 && !busy && phase_out == 2'd0 && pc_advance == 2'd0 && !nop_active,
              "R10 reset state", {wreg_out, busy, phase_out}, 0);
        rst = 1'b0;
        tick();

        // Vector table walk: R2 R3 R4 R5 plus timing
        for (int i = 0; i < NV; i++) begin
            file_write(VEC[i].addr, VEC[i].init);
            load_bsr(VEC[i].bsr);
            run_instr(VEC[i].word, VEC[i].two, int'(VEC[i].cyc));
            file_read(VEC[i].addr, rd);
            if (VEC[i].word[9]) begin
                check(rd == VEC[i].res, "R2 R4 R5 file result", rd, VEC[i].res);
                check(wreg_out == w_model, "R3 working register kept", wreg_out, w_model);
            end else begin
                check(wreg_out == VEC[i].res, "R2 R3 R5 working register result", wreg_out, VEC[i].res);
                check(rd == VEC[i].init, "R3 R4 file byte kept", rd, VEC[i].init);
                w_model = VEC[i].res;
            end
        end

        // R1: words with a foreign opcode are not accepted
        instr_word = 16'h2810; instr_valid = 1'b1;
        tick();
        check(!busy && wreg_out == w_model, "R1 foreign opcode 0x2810", busy, 0);
        instr_word = 16'h0000;
        tick();
        instr_valid = 1'b0;
        check(!busy && wreg_out == w_model, "R1 foreign opcode 0x0000", busy, 0);

        // R8 held instr_valid ignored while busy; R11 external write ignored while busy
        file_write(12'h040, 8'h03);
        file_write(12'h041, 8'h11);
        instr_word = 16'h2C40; next_two_word = 1'b0; instr_valid = 1'b1;
        tick();
        instr_word = 16'h2C41;
        ext_wr_en = 1'b1; ext_wr_addr = 12'h041; ext_wr_data = 8'h55;
        tick();
        instr_valid = 1'b0; ext_wr_en = 1'b0;
        wait_done();
        tick();
        check(!busy && wreg_out == 8'h02, "R8 second word not taken", wreg_out, 8'h02);
        file_read(12'h041, rd);
        check(rd == 8'h11, "R11 external write while busy", rd, 8'h11);
        w_model = 8'h02;

        // R10: reset aborts an instruction and clears the bank selector
        load_bsr(4'h6);
        file_write(12'h012, 8'h09);
        file_write(12'h612, 8'h09);
        file_write(12'h050, 8'h01);
        instr_word = 16'h2C50; next_two_word = 1'b1; instr_valid = 1'b1;
        tick();
        instr_valid = 1'b0;
        repeat (4) tick();
        rst = 1'b1;
        tick();
        check(!busy && !nop_active && phase_out == 2'd0 && wreg_out == 8'h00,
              "R10 reset mid instruction", {busy, phase_out, wreg_out}, 0);
        rst = 1'b0;
        tick();
        run_instr(16'h2F12, 1'b0, 1);
        file_read(12'h012, rd);
        check(rd == 8'h08, "R10 R4 bank selector cleared to bank 0", rd, 8'h08);
        file_read(12'h612, rd);
        check(rd == 8'h09, "R10 R4 old bank untouched", rd, 8'h09);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule